// File: doc/BRIEF.md
# Two-Slot Static Issue Checker

This block sits in the decode stage of a two-way, in-order pipeline. Each cycle it looks at one 64-bit fetch packet holding two 32-bit instructions. Slot A executes integer arithmetic and branches, and slot B executes loads and stores. The block decodes both words and judges whether they may leave together. It checks three things: whether each word fits its slot, whether the later word reads a register that the earlier word writes, and whether either word consumes a value loaded in the previous cycle. From this it drives one issue flag per slot, a hazard stall and the register indices for a register file with four read ports and two write ports.

Packets arrive on a valid/ready stream. `pkt_ready` is high only in the cycle in which the last instruction of the packet issues. While `pkt_valid` is high and `pkt_ready` is low, the producer must hold `pkt_data` unchanged. A packet that cannot pair is taken apart in program order: the upper word issues alone first, and the lower word issues alone in the next cycle. Each of these single words uses the slot that its type selects.

Top module: `dual_issue_checker`

## Requirements
- R1: After reset, with `pkt_valid` low, neither slot issues, `hold_stall` is low and `pkt_ready` is low.
- R2: The program-order first word is `pkt_data[63:32]` and the second is `pkt_data[31:0]`. Field positions are opcode [31:26], rs [25:21], rt [20:16] and rd [15:11]. An arithmetic or branch word first, followed by a load or store second that has no dependency, issues in one cycle: A from the first word, B from the second, with `pkt_ready` high.
- R3: Slot A takes only opcode 0x00 (register form, any function code), 0x08, 0x09, 0x04 and 0x05. Slot B takes only 0x23 (load) and 0x2B (store). A packet whose types do not fit is split, and each word issues alone in the slot its type selects.
- R4: The first word's destination is rd for the register form and rt for the immediate forms and the load. If that destination matches a source of the second word (rs/rt, or the store's base rs and data rt), the first word issues alone with `pkt_ready` low. The second word issues in the next cycle with `pkt_ready` high.
- R5: A destination of register 0 never creates a dependency, and it never asserts a write enable.
- R6: If a source of any word about to issue equals the nonzero destination of a load that issued in the previous cycle, `hold_stall` is high, neither slot issues and `pkt_ready` is low for exactly one cycle.
- R7: A word with any other opcode cannot pair. It takes one cycle alone with no issue flag raised, and the other word of the packet still issues in its own cycle.
- R8: A branch has no destination. The packet after a branch packet issues under the normal rules, with no stall added and none removed.
- R9: A slot that does not issue drives zero on its source, destination and write-enable outputs. Slot B's second source is the store data register.
- R10: Nothing issues while `pkt_valid` is low, and `pkt_ready` is never high without `pkt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Fetch packet present |
| pkt_data | input | 64 | Two instructions, program-order first in the upper half |
| pkt_ready | output | 1 | Packet fully issued; fetch may advance |
| hold_stall | output | 1 | Load-use hold this cycle |
| a_issue | output | 1 | Slot A issues |
| a_src1 | output | 5 | Slot A first read index |
| a_src2 | output | 5 | Slot A second read index |
| a_dst | output | 5 | Slot A destination index |
| a_wen | output | 1 | Slot A writes a register |
| b_issue | output | 1 | Slot B issues |
| b_src1 | output | 5 | Slot B base register index |
| b_src2 | output | 5 | Slot B store data index |
| b_dst | output | 5 | Slot B load destination index |
| b_wen | output | 1 | Slot B writes a register |

## Verification
A load-use hold and a packet split can act on the same packet. The bench provokes this with a packet whose first word is a load (the wrong type for the first position) that reads a register loaded one cycle earlier, and whose second word reads the register that first load writes. The expected sequence is four cycles: a hold, then the load alone in slot B, then a second hold caused by the split-off load, then the arithmetic word alone in slot A with `pkt_ready` high. The scoreboard judges every one of those cycles. It also judges a branch packet followed directly by its delay-slot packet, so that the branch is seen to add no stall.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned RIX_W = 5;

  localparam logic [OP_W-1:0] OP_RFORM = 6'h00;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  typedef enum logic [2:0] {
    IC_ILL = 3'd0,
    IC_ALU = 3'd1,
    IC_BR  = 3'd2,
    IC_LD  = 3'd3,
    IC_ST  = 3'd4
  } iclass_e;

  typedef struct packed {
    iclass_e          cls;
    logic [RIX_W-1:0] s1;
    logic [RIX_W-1:0] s2;
    logic [RIX_W-1:0] dst;
    logic             u1;
    logic             u2;
    logic             wr;
  } dec_t;

  function automatic logic fits_a(iclass_e c);
    return (c == IC_ALU) || (c == IC_BR);
  endfunction

  function automatic logic fits_b(iclass_e c);
    return (c == IC_LD) || (c == IC_ST);
  endfunction

  function automatic logic reads_reg(dec_t d, logic [RIX_W-1:0] r);
    return (r != '0) && ((d.u1 && d.s1 == r) || (d.u2 && d.s2 == r));
  endfunction
endpackage

// File: rtl/dip_decode.sv
module dip_decode
  import dip_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  localparam int unsigned OP_HI = INSN_W - 1;
  localparam int unsigned RS_HI = OP_HI - OP_W;
  localparam int unsigned RT_HI = RS_HI - RIX_W;
  localparam int unsigned RD_HI = RT_HI - RIX_W;
  localparam int unsigned LO_HI = RD_HI - RIX_W;

  logic [OP_W-1:0]  op;
  logic [RIX_W-1:0] rs, rt, rd;
  logic             unused_low;

  assign op = insn[OP_HI -: OP_W];
  assign rs = insn[RS_HI -: RIX_W];
  assign rt = insn[RT_HI -: RIX_W];
  assign rd = insn[RD_HI -: RIX_W];
  assign unused_low = ^insn[LO_HI:0];

  always_comb begin
    dec = '0;
    unique case (op)
      OP_RFORM: begin
        dec.cls = IC_ALU;
        dec.s1 = rs; dec.u1 = 1'b1;
        dec.s2 = rt; dec.u2 = 1'b1;
        dec.dst = rd; dec.wr = 1'b1;
      end
      OP_ADDI, OP_ADDIU: begin
        dec.cls = IC_ALU;
        dec.s1 = rs; dec.u1 = 1'b1;
        dec.dst = rt; dec.wr = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        dec.cls = IC_BR;
        dec.s1 = rs; dec.u1 = 1'b1;
        dec.s2 = rt; dec.u2 = 1'b1;
      end
      OP_LOAD: begin
        dec.cls = IC_LD;
        dec.s1 = rs; dec.u1 = 1'b1;
        dec.dst = rt; dec.wr = 1'b1;
      end
      OP_STORE: begin
        dec.cls = IC_ST;
        dec.s1 = rs; dec.u1 = 1'b1;
        dec.s2 = rt; dec.u2 = 1'b1;
      end
      default: dec.cls = IC_ILL;
    endcase
  end
endmodule

// File: rtl/dip_pair_check.sv
module dip_pair_check
  import dip_pkg::*;
(
  input  dec_t older,
  input  dec_t younger,
  output logic pair_ok
);
  logic types_fit;
  logic raw_dep;

  assign types_fit = fits_a(older.cls) && fits_b(younger.cls);
  // register 0 is filtered inside reads_reg
  assign raw_dep   = older.wr && reads_reg(younger, older.dst);
  assign pair_ok   = types_fit && !raw_dep;
endmodule

// File: rtl/dip_hazard_track.sv
module dip_hazard_track
  import dip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             pair_ok,
  input  logic             stall,
  input  logic             ld_fire,
  input  logic [RIX_W-1:0] ld_dst,
  output logic             in_second,
  output logic [RIX_W-1:0] last_ld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_second <= 1'b0;
      last_ld   <= '0;
    end else begin
      if (go) in_second <= !in_second && !pair_ok;
      last_ld <= ld_fire ? ld_dst : '0;
    end
  end

  // R6
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R6
  held_cycle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (last_ld == '0));
endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
  import dip_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned RIDX_W = RIX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [2*INSN_W-1:0] pkt_data,
  output logic                pkt_ready,
  output logic                hold_stall,
  output logic                a_issue,
  output logic [RIDX_W-1:0]   a_src1,
  output logic [RIDX_W-1:0]   a_src2,
  output logic [RIDX_W-1:0]   a_dst,
  output logic                a_wen,
  output logic                b_issue,
  output logic [RIDX_W-1:0]   b_src1,
  output logic [RIDX_W-1:0]   b_src2,
  output logic [RIDX_W-1:0]   b_dst,
  output logic                b_wen
);
  localparam int unsigned N_WORDS = 2;
  localparam int unsigned PKT_W   = N_WORDS * INSN_W;

  dec_t             dec [N_WORDS];
  logic             pair_ok;
  logic             in_second;
  logic [RIX_W-1:0] last_ld;
  logic             act0, act1, lu_hit, go, iss0, iss1;
  dec_t             sel_a, sel_b;
  logic             a_on, b_on;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_dec
    dip_decode #(.INSN_W(INSN_W)) u_dec (
      .insn (pkt_data[PKT_W-1-w*INSN_W -: INSN_W]),
      .dec  (dec[w])
    );
  end

  dip_pair_check u_pair (
    .older   (dec[0]),
    .younger (dec[1]),
    .pair_ok (pair_ok)
  );

  // which words are candidates this cycle
  assign act0   = !in_second;
  assign act1   = in_second || pair_ok;
  assign lu_hit = (act0 && reads_reg(dec[0], last_ld)) ||
                  (act1 && reads_reg(dec[1], last_ld));
  assign go     = pkt_valid && !lu_hit;
  assign iss0   = go && act0 && (dec[0].cls != IC_ILL);
  assign iss1   = go && act1 && (dec[1].cls != IC_ILL);

  assign hold_stall = pkt_valid && lu_hit;
  assign pkt_ready  = go && act1;

  always_comb begin
    sel_a = '0; a_on = 1'b0;
    sel_b = '0; b_on = 1'b0;
    if (iss0 && fits_a(dec[0].cls)) begin
      sel_a = dec[0]; a_on = 1'b1;
    end else if (iss1 && fits_a(dec[1].cls)) begin
      sel_a = dec[1]; a_on = 1'b1;
    end
    if (iss0 && fits_b(dec[0].cls)) begin
      sel_b = dec[0]; b_on = 1'b1;
    end else if (iss1 && fits_b(dec[1].cls)) begin
      sel_b = dec[1]; b_on = 1'b1;
    end
  end

  assign a_issue = a_on;
  assign a_src1  = (a_on && sel_a.u1) ? RIDX_W'(sel_a.s1) : '0;
  assign a_src2  = (a_on && sel_a.u2) ? RIDX_W'(sel_a.s2) : '0;
  assign a_dst   = (a_on && sel_a.wr) ? RIDX_W'(sel_a.dst) : '0;
  assign a_wen   = a_on && sel_a.wr && (sel_a.dst != '0);

  assign b_issue = b_on;
  assign b_src1  = (b_on && sel_b.u1) ? RIDX_W'(sel_b.s1) : '0;
  assign b_src2  = (b_on && sel_b.u2) ? RIDX_W'(sel_b.s2) : '0;
  assign b_dst   = (b_on && sel_b.wr) ? RIDX_W'(sel_b.dst) : '0;
  assign b_wen   = b_on && sel_b.wr && (sel_b.dst != '0);

  dip_hazard_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .pair_ok   (pair_ok),
    .stall     (hold_stall),
    .ld_fire   (b_on && (sel_b.cls == IC_LD)),
    .ld_dst    (sel_b.dst),
    .in_second (in_second),
    .last_ld   (last_ld)
  );

  // R6
  stall_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stall |-> (!a_issue && !b_issue && !pkt_ready));

  // R10
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> pkt_valid);

  // R9
  idle_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_issue |-> (a_src1 == '0 && a_src2 == '0 && a_dst == '0 && !a_wen));

  // R9
  idle_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_issue |-> (b_src1 == '0 && b_src2 == '0 && b_dst == '0 && !b_wen));

  // R5
  wen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wen |-> a_dst != '0) and (b_wen |-> b_dst != '0));

  // R4
  split_finishes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !hold_stall && !pkt_ready && $stable(pkt_data)) |=>
      (!pkt_valid || $changed(pkt_data) || hold_stall || pkt_ready));
endmodule

// File: tb/tb_dual_issue_checker.sv
`timescale 1ns/1ps
module tb_dual_issue_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_data = '0;
  logic        pkt_ready, hold_stall;
  logic        a_issue, a_wen, b_issue, b_wen;
  logic [4:0]  a_src1, a_src2, a_dst, b_src1, b_src2, b_dst;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dual_issue_checker dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .hold_stall(hold_stall),
    .a_issue(a_issue), .a_src1(a_src1), .a_src2(a_src2), .a_dst(a_dst), .a_wen(a_wen),
    .b_issue(b_issue), .b_src1(b_src1), .b_src2(b_src2), .b_dst(b_dst), .b_wen(b_wen)
  );

  typedef struct {
    logic ai, bi, st, rd;
    logic [4:0] ad, as1, bd, bs1;
    string tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] rf(int rs, int rt, int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] imm(logic [5:0] op, int rs, int rt, int k);
    return {op, 5'(rs), 5'(rt), 16'(k)};
  endfunction

  task automatic ex(logic ai, logic bi, logic st, logic rd,
                    int ad, int as1, int bd, int bs1, string tag);
    exp_t e;
    e.ai = ai; e.bi = bi; e.st = st; e.rd = rd;
    e.ad = 5'(ad); e.as1 = 5'(as1); e.bd = 5'(bd); e.bs1 = 5'(bs1); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic present(logic [31:0] w0, logic [31:0] w1, int n);
    @(posedge clk); #1;
    pkt_valid = 1'b1;
    pkt_data  = {w0, w1};
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    pkt_valid = 1'b0;
  endtask

  // monitor: pops one expected item per cycle with a packet present
  always @(negedge clk) begin
    if (rst_n && pkt_valid) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected cycle: no expectation queued");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (a_issue !== e.ai || b_issue !== e.bi || hold_stall !== e.st ||
            pkt_ready !== e.rd || a_dst !== e.ad || a_src1 !== e.as1 ||
            b_dst !== e.bd || b_src1 !== e.bs1) begin
          fails++;
          $display("FAIL %s: got ai=%0b bi=%0b st=%0b rd=%0b ad=%0d as1=%0d bd=%0d bs1=%0d exp ai=%0b bi=%0b st=%0b rd=%0b ad=%0d as1=%0d bd=%0d bs1=%0d",
                   e.tag, a_issue, b_issue, hold_stall, pkt_ready, a_dst, a_src1,
                   b_dst, b_src1, e.ai, e.bi, e.st, e.rd, e.ad, e.as1, e.bd, e.bs1);
        end
      end
    end
  end

  task automatic quiet_check(string tag);
    @(negedge clk);
    tests++;
    if (a_issue || b_issue || hold_stall || pkt_ready || a_wen || b_wen) begin
      fails++;
      $display("FAIL %s: got ai=%0b bi=%0b st=%0b rd=%0b exp all 0",
               tag, a_issue, b_issue, hold_stall, pkt_ready);
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    quiet_check("R1 reset state");

    // R2 legal pair: add r3,r1,r2 | lw r4,0(r5)
    ex(1,1,0,1, 3,1, 4,5, "R2 legal pair");
    present(rf(1,2,3), imm(6'h23,5,4,0), 1);

    // R2 second legal pair, no use of r4: add r6,r7,r8 | sw r9,0(r10)
    ex(1,1,0,1, 6,7, 0,10, "R2 pair with store");
    present(rf(7,8,6), imm(6'h2B,10,9,0), 1);

    // R6 load-use through slot A: add r13,r1,r2 | lw r11,4(r12) ; add r14,r11,r1 | sw r2,0(r3)
    ex(1,1,0,1, 13,1, 11,12, "R6 load producer");
    present(rf(1,2,13), imm(6'h23,12,11,4), 1);
    ex(0,0,1,0, 0,0, 0,0, "R6 hold slot A use");
    ex(1,1,0,1, 14,11, 0,3, "R6 release after hold");
    present(rf(11,1,14), imm(6'h2B,3,2,0), 2);

    // R6 load-use through store base: addi r20,r0,5 | lw r15 ; addi r21,r0,1 | sw r17,0(r15)
    ex(1,1,0,1, 20,0, 15,16, "R6 producer two");
    present(imm(6'h08,0,20,5), imm(6'h23,16,15,0), 1);
    ex(0,0,1,0, 0,0, 0,0, "R6 hold store base");
    ex(1,1,0,1, 21,0, 0,15, "R6 release store base");
    present(imm(6'h09,0,21,1), imm(6'h2B,15,17,0), 2);

    // R4 RAW to load base: addi r5,r6,1 | lw r7,0(r5)
    ex(1,0,0,0, 5,6, 0,0, "R4 first word alone");
    ex(0,1,0,1, 0,0, 7,5, "R4 second word next");
    present(imm(6'h08,6,5,1), imm(6'h23,5,7,0), 2);

    // R4 RAW to store data: add r8,r1,r2 | sw r8,0(r9)
    ex(1,0,0,0, 8,1, 0,0, "R4 store data dep first");
    ex(0,1,0,1, 0,0, 0,9, "R4 store data dep second");
    present(rf(1,2,8), imm(6'h2B,9,8,0), 2);

    // R5 r0 destination no dep: add r0,r1,r2 | lw r3,0(r0)
    ex(1,1,0,1, 0,1, 3,0, "R5 r0 no dependency");
    present(rf(1,2,0), imm(6'h23,0,3,0), 1);

    // R3 swapped: lw r9,0(r1) | add r10,r2,r3
    ex(0,1,0,0, 0,0, 9,1, "R3 swapped load alone");
    ex(1,0,0,1, 10,2, 0,0, "R3 swapped alu next");
    present(imm(6'h23,1,9,0), rf(2,3,10), 2);

    // R3 two memory ops: lw r12,0(r1) | lw r13,0(r2)
    ex(0,1,0,0, 0,0, 12,1, "R3 two loads first");
    ex(0,1,0,1, 0,0, 13,2, "R3 two loads second");
    present(imm(6'h23,1,12,0), imm(6'h23,2,13,0), 2);

    // R7 unknown opcode first: 0x3F | lw r14,0(r1)
    ex(0,0,0,0, 0,0, 0,0, "R7 unknown opcode no-op");
    ex(0,1,0,1, 0,0, 14,1, "R7 partner issues next");
    present(imm(6'h3F,13,13,0), imm(6'h23,1,14,0), 2);

    // R8 branch then delay-slot packet: beq r1,r2 | sw r3,0(r4) ; add r5,r6,r7 | lw r8,0(r9)
    ex(1,1,0,1, 0,1, 0,4, "R8 branch packet");
    present(imm(6'h04,1,2,4), imm(6'h2B,4,3,0), 1);
    ex(1,1,0,1, 5,6, 8,9, "R8 delay slot packet");
    present(rf(6,7,5), imm(6'h23,9,8,0), 1);

    // R6 with R3: addi r2,r0,1 | lw r22,0(r3) ; lw r23,0(r22) | add r24,r23,r1
    ex(1,1,0,1, 2,0, 22,3, "R6 producer three");
    present(imm(6'h08,0,2,1), imm(6'h23,3,22,0), 1);
    ex(0,0,1,0, 0,0, 0,0, "R6 hold before split load");
    ex(0,1,0,0, 0,0, 23,22, "R3 split load alone");
    ex(0,0,1,0, 0,0, 0,0, "R6 hold after split load");
    ex(1,0,0,1, 24,23, 0,0, "R3 alu after hold");
    present(imm(6'h23,22,23,0), rf(23,1,24), 4);

    idle();
    quiet_check("R10 idle no issue");
    quiet_check("R10 idle second cycle");

    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d left exp 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule